// File: doc/BRIEF.md
# BCD Calendar Clock with Snapshot Register Bank

This block keeps time of day and calendar date in packed BCD: seconds, minutes, hours on a 24-hour scale, day of week, date, month and a two-digit year. The running counters are never read or written by the bus directly. A bank of bus-visible byte registers holds a snapshot of them, and that bank occupies the eight highest addresses of a byte-wide address space. The block advances by one second on each cycle-wide pulse of `tick`, which comes from an external one-per-second source. On that same step it refreshes the snapshot, unless one of two halt bits in the control register is set.

Software that wants a consistent reading sets the read-halt bit. It then reads the frozen bank, while the counters keep running, and clears the bit. To set the time, software raises the write-halt bit and writes the new values into the bank. Clearing that bit copies the bank into the counters. A stop bit held in the top bit of the seconds register gates the tick completely. The bus port is synchronous: writes take effect at the clock edge, and reads return data combinationally while `sel` is high and `wr` is low.

Top module: `rtc_snapshot_cal`

## Requirements
- R1: The bank responds only when every address bit above bit 2 is 1. The low three address bits select the register: 7 year, 6 month, 5 date, 4 day of week, 3 hours, 2 minutes, 1 seconds, 0 control. A read outside the bank returns 0x00, and a write outside it changes nothing.
- R2: Unused bits are cleared when written and always read as 0. The masks are month 0x1F, date 0x3F, day of week 0x07, hours 0x3F, minutes 0x7F and seconds 0x7F plus the stop bit. Control bits 5..0 always read 0.
- R3: When neither halt bit is set and the stop bit is clear, a `tick` sampled at a clock edge advances the counters by one second. At that same edge it copies all seven new values into the bank at once.
- R4: While control bit 6 (read halt) or control bit 7 (write halt) is 1, the bank does not follow the counters, but the counters still advance on every tick. The first tick after both bits are 0 again shows the full elapsed count.
- R5: A write to the control register that takes bit 7 from 1 to 0 loads all seven bank values into the counters. A tick in that same cycle is absorbed, so the next advance starts from the loaded values.
- R6: Seconds bit 7 is the stop bit. While it is 1, ticks are ignored. It can be set or cleared without the write-halt bit, and it reads back in place.
- R7: Seconds and minutes wrap from 59 to 00 and carry. Hours wrap from 23 to 00 and carry into the date and the day of week.
- R8: The date wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 28 or 29 for month 02, and 31 otherwise. February has 29 days when the year is a multiple of 4, and year 00 counts as such a year. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R9: The day of week runs from 01 to 07 and goes from 07 back to 01 at midnight, whatever the date is.
- R10: A tick that arrives in the same cycle as a bus write to a time register (offsets 1 to 7) is applied in the next cycle. The write lands first, and then the whole bank is refreshed together.
- R11: Reset clears both halt bits and the stop bit. It loads counters and bank with year 00, month 01, date 01, day 01, 00:00:00.
- R12: A control write that sets read halt in the same cycle as a tick does not block that step's refresh. The bank still shows the new time, and it freezes from the next tick on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| sel | input | 1 | Bus access strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0x00 when not reading the bank |

## Verification
The hardest situations to reach are the ones where a tick meets a bus cycle in the same clock: a tick with a time-register write, and a tick with the write that sets read halt. Both depend on exact cycle alignment that ordinary use almost never produces. The bench can drive `tick` together with any bus write, and it does so on purpose in directed cases. Its random phase mixes such collisions with halt toggles, stop toggles and times seeded close to month and year ends, so that rollovers occur after only a few ticks.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int NF     = 7;   // time fields
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HR   = 2;
    localparam int F_DOW  = 3;
    localparam int F_DATE = 4;
    localparam int F_MON  = 5;
    localparam int F_YR   = 6;

    typedef logic [7:0]        bcd_t;
    typedef bcd_t [NF-1:0]     tvec_t;

    typedef struct packed {
        tvec_t live;
        tvec_t vis;
        logic  stop;
        logic  wbit;
        logic  rbit;
        logic  pend;
    } cal_state_t;

    // index 6 (year) first
    localparam tvec_t RESET_TIME = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    function automatic bcd_t field_mask(input logic [2:0] f);
        case (f)
            3'd0:    field_mask = 8'h7F;
            3'd1:    field_mask = 8'h7F;
            3'd2:    field_mask = 8'h3F;
            3'd3:    field_mask = 8'h07;
            3'd4:    field_mask = 8'h3F;
            3'd5:    field_mask = 8'h1F;
            default: field_mask = 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step
    import rtc_cal_pkg::*;
(
    input  logic en,
    input  bcd_t cur,
    input  bcd_t max_v,
    input  bcd_t min_v,
    output bcd_t nxt,
    output logic carry
);

    bcd_t inc;
    logic at_top;

    always_comb begin
        if (cur[3:0] >= 4'd9) inc = {cur[7:4] + 4'd1, 4'd0};
        else                  inc = {cur[7:4], cur[3:0] + 4'd1};
        at_top = (cur >= max_v);
        carry  = en && at_top;
        if (!en)        nxt = cur;
        else if (at_top) nxt = min_v;
        else            nxt = inc;
    end

endmodule

// File: rtl/rtc_cal_advance.sv
module rtc_cal_advance
    import rtc_cal_pkg::*;
(
    input  tvec_t cur,
    output tvec_t nxt
);

    logic [7:0] yr_bin;
    logic       leap;
    bcd_t       mlen;
    tvec_t      maxv;
    tvec_t      minv;
    logic       en    [NF];
    logic       carry [NF];

    always_comb begin
        yr_bin = 8'(cur[F_YR][7:4]) * 8'd10 + 8'(cur[F_YR][3:0]);
        leap   = (yr_bin[1:0] == 2'b00);
        case (cur[F_MON])
            8'h02:                      mlen = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: mlen = 8'h30;
            default:                    mlen = 8'h31;
        endcase
        maxv = {8'h99, 8'h12, mlen, 8'h07, 8'h23, 8'h59, 8'h59};
        minv = RESET_TIME;
    end

    // carry sources: date and day-of-week both hang off the hours carry
    generate
        for (genvar i = 0; i < NF; i++) begin : g_field
            localparam int SRC = (i == F_DATE) ? F_HR :
                                 (i == F_MON)  ? F_DATE : i - 1;
            if (i == 0) begin : g_first
                assign en[i] = 1'b1;
            end else begin : g_chain
                assign en[i] = carry[SRC];
            end
            rtc_bcd_step u_step (
                .en    (en[i]),
                .cur   (cur[i]),
                .max_v (maxv[i]),
                .min_v (minv[i]),
                .nxt   (nxt[i]),
                .carry (carry[i])
            );
        end
    endgenerate

endmodule

// File: rtl/rtc_snapshot_cal.sv
module rtc_snapshot_cal
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    localparam int IDX_W = 3;

    cal_state_t       state_q, state_d;
    tvec_t            live_nxt;
    logic             in_range, bus_wr, time_wr, commit, tick_req, advance;
    logic [IDX_W-1:0] idx, fidx;

    rtc_cal_advance u_adv (
        .cur (state_q.live),
        .nxt (live_nxt)
    );

    always_comb begin
        state_d  = state_q;
        in_range = &addr[ADDR_W-1:IDX_W];
        idx      = addr[IDX_W-1:0];
        fidx     = idx - 3'd1;
        bus_wr   = sel && wr && in_range;
        time_wr  = bus_wr && (idx != 3'd0);
        commit   = bus_wr && (idx == 3'd0) && state_q.wbit && !wdata[7];
        tick_req = tick || state_q.pend;
        advance  = tick_req && !state_q.stop && !time_wr && !commit;

        state_d.pend = tick_req && !state_q.stop && time_wr;

        if (advance) begin
            state_d.live = live_nxt;
            if (!state_q.wbit && !state_q.rbit)
                state_d.vis = live_nxt;
        end

        if (bus_wr) begin
            if (idx == 3'd0) begin
                state_d.wbit = wdata[7];
                state_d.rbit = wdata[6];
            end else begin
                state_d.vis[fidx] = wdata & field_mask(fidx);
                if (idx == 3'd1)
                    state_d.stop = wdata[7];
            end
        end

        if (commit)
            state_d.live = state_q.vis;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.live <= RESET_TIME;
            state_q.vis  <= RESET_TIME;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (sel && !wr && in_range) begin
            case (idx)
                3'd0:    rdata = {state_q.wbit, state_q.rbit, 6'b0};
                3'd1:    rdata = {state_q.stop, state_q.vis[F_SEC][6:0]};
                default: rdata = state_q.vis[fidx];
            endcase
        end
    end

endmodule

// File: rtl/rtc_snapshot_cal_chk.sv
module rtc_snapshot_cal_chk
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rdata,
    input tvec_t             vis,
    input tvec_t             live,
    input logic              stop,
    input logic              wbit,
    input logic              rbit
);

    logic inr;
    assign inr = &addr[ADDR_W-1:3];

    a_r1_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr && !inr) |-> (rdata == 8'h00));

    a_r2_month_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr && inr && addr[2:0] == 3'd6) |-> (rdata[7:5] == 3'b000));

    a_r2_ctrl_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr && inr && addr[2:0] == 3'd0) |-> (rdata[5:0] == 6'd0));

    a_r4_halt_freezes_bank: assert property (@(posedge clk) disable iff (!rst_n)
        ((wbit || rbit) && !(sel && wr)) |=> $stable(vis));

    a_r6_stop_holds_counters: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !(sel && wr)) |=> $stable(live));

endmodule

bind rtc_snapshot_cal rtc_snapshot_cal_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel),
    .wr    (wr),
    .addr  (addr),
    .rdata (rdata),
    .vis   (state_q.vis),
    .live  (state_q.live),
    .stop  (state_q.stop),
    .wbit  (state_q.wbit),
    .rbit  (state_q.rbit)
);

// File: tb/rtc_snapshot_cal_test.sv
`timescale 1ns/1ps
module rtc_snapshot_cal_test;

    localparam int ADDR_W = 19;
    typedef int tv_t [7];

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              sel = 1'b0;
    logic              wr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic [7:0]        rdata;

    int checks = 0;
    int fails  = 0;

    tv_t m_live, m_vis;
    bit  m_stop, m_w, m_r;

    rtc_snapshot_cal #(.ADDR_W(ADDR_W)) uut (
        .clk, .rst_n, .tick, .sel, .wr, .addr, .wdata, .rdata
    );

    always #2 clk = ~clk;

    initial begin
        #(4ns * 150000);
        fails++;
        $display("FAIL watchdog: run did not complete (got hang, expected finish)");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    function automatic logic [7:0] enc(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dec(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int mdays(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    // field order: sec, min, hr, dow, date, mon, yr
    function automatic tv_t adv(input tv_t t);
        tv_t n = t;
        n[0]++;
        if (n[0] == 60) begin
            n[0] = 0; n[1]++;
            if (n[1] == 60) begin
                n[1] = 0; n[2]++;
                if (n[2] == 24) begin
                    n[2] = 0;
                    n[3] = (n[3] == 7) ? 1 : n[3] + 1;
                    n[4]++;
                    if (n[4] > mdays(t[5], t[6])) begin
                        n[4] = 1; n[5]++;
                        if (n[5] == 13) begin
                            n[5] = 1;
                            n[6] = (n[6] == 99) ? 0 : n[6] + 1;
                        end
                    end
                end
            end
        end
        return n;
    endfunction

    function automatic logic [7:0] mask_of(input int f);
        case (f)
            2: return 8'h3F; 3: return 8'h07; 4: return 8'h3F;
            5: return 8'h1F; 6: return 8'hFF; default: return 8'h7F;
        endcase
    endfunction

    function automatic logic [7:0] expect_reg(input int idx);
        if (idx == 0) return {m_w, m_r, 6'b0};
        if (idx == 1) return {m_stop, enc(m_vis[0])[6:0]};
        return enc(m_vis[idx-1]);
    endfunction

    task automatic model_tick();
        if (!m_stop) begin
            m_live = adv(m_live);
            if (!m_w && !m_r) m_vis = m_live;
        end
    endtask

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        model_tick();
    endtask

    task automatic bus_write(input int idx, input logic [7:0] d, input bit tk);
        bit old_stop = m_stop;
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; tick = tk;
        addr = {{(ADDR_W-3){1'b1}}, 3'(idx)}; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; tick = 1'b0;
        if (idx == 0) begin
            if (tk) model_tick();
            if (m_w && !d[7]) m_live = m_vis;
            m_w = d[7]; m_r = d[6];
        end else begin
            m_vis[idx-1] = dec(d & mask_of(idx-1));
            if (idx == 1) m_stop = d[7];
            if (tk && !old_stop && !m_stop) model_tick();
        end
    endtask

    task automatic read_chk(input int idx, input string tag);
        logic [7:0] got;
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = {{(ADDR_W-3){1'b1}}, 3'(idx)};
        #1 got = rdata;
        sel = 1'b0;
        check(tag, got, expect_reg(idx));
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 8; i++) read_chk(i, tag);
    endtask

    task automatic set_time(input int yr, input int mo, input int dt, input int dw,
                            input int hr, input int mi, input int se);
        bus_write(0, 8'h80, 1'b0);
        bus_write(7, enc(yr), 1'b0);
        bus_write(6, enc(mo), 1'b0);
        bus_write(5, enc(dt), 1'b0);
        bus_write(4, enc(dw), 1'b0);
        bus_write(3, enc(hr), 1'b0);
        bus_write(2, enc(mi), 1'b0);
        bus_write(1, enc(se), 1'b0);
        bus_write(0, 8'h00, 1'b0);
    endtask

    initial begin
        logic [7:0] got;
        void'($urandom(32'd20240229));
        m_live = '{0, 0, 0, 1, 1, 1, 0};
        m_vis  = m_live;
        m_stop = 0; m_w = 0; m_r = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state, R1 register offsets
        read_all("R11 reset values");

        // R1 outside the bank
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = {{(ADDR_W-4){1'b1}}, 4'b0001};
        #1 got = rdata; sel = 1'b0;
        check("R1 outside read zero", got, 8'h00);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = {{(ADDR_W-4){1'b1}}, 4'b0001}; wdata = 8'h45;
        @(negedge clk); sel = 1'b0; wr = 1'b0;
        read_chk(1, "R1 outside write ignored");

        // R2 masking, under read halt so no commit happens
        bus_write(0, 8'h7F, 1'b0);
        read_chk(0, "R2 control low bits");
        bus_write(6, 8'hF2, 1'b0); read_chk(6, "R2 month mask");
        bus_write(5, 8'hD5, 1'b0); read_chk(5, "R2 date mask");
        bus_write(4, 8'hFD, 1'b0); read_chk(4, "R2 dow mask");
        bus_write(3, 8'hE3, 1'b0); read_chk(3, "R2 hours mask");
        bus_write(2, 8'hC5, 1'b0); read_chk(2, "R2 minutes mask");
        bus_write(0, 8'h00, 1'b0);

        // R7 R8 R9 rollovers
        set_time(24, 2, 28, 7, 23, 59, 59); do_tick(); read_all("R7 R9 R8 leap 28->29");
        set_time(24, 2, 29, 3, 23, 59, 59); do_tick(); read_all("R8 leap 29->03-01");
        set_time(23, 2, 28, 2, 23, 59, 59); do_tick(); read_all("R8 common Feb end");
        set_time(23, 4, 30, 6, 23, 59, 59); do_tick(); read_all("R8 30-day month");
        set_time(23, 12, 31, 7, 23, 59, 59); do_tick(); read_all("R8 R9 year end");
        set_time(99, 12, 31, 5, 23, 59, 59); do_tick(); read_all("R8 year 99 wrap");
        set_time(0, 2, 28, 1, 23, 59, 59); do_tick(); read_all("R8 year 00 leap");
        set_time(5, 7, 9, 4, 10, 59, 58);
        do_tick(); read_chk(1, "R3 plain step");
        do_tick(); read_all("R7 minute carry");

        // R4 read halt
        bus_write(0, 8'h40, 1'b0);
        repeat (3) do_tick();
        read_all("R4 frozen under read halt");
        bus_write(0, 8'h00, 1'b0);
        do_tick(); read_all("R4 elapsed count after halt");

        // R5 write halt and commit
        bus_write(0, 8'h80, 1'b0);
        do_tick(); read_chk(1, "R4 frozen under write halt");
        bus_write(3, enc(8), 1'b0);
        bus_write(2, enc(30), 1'b0);
        bus_write(0, 8'h00, 1'b0);
        read_all("R5 after commit");
        do_tick(); read_all("R5 step from committed time");

        // R6 stop bit without write halt
        bus_write(1, 8'h80 | enc(20), 1'b0);
        repeat (3) do_tick();
        read_all("R6 stopped");
        bus_write(1, enc(20), 1'b0);
        do_tick(); read_all("R6 resumed");

        // R10 tick colliding with a time write
        bus_write(2, enc(11), 1'b1); read_all("R10 deferred tick");
        bus_write(0, 8'h40, 1'b0);
        bus_write(5, enc(12), 1'b1); read_all("R10 deferred tick under halt");
        bus_write(0, 8'h00, 1'b0);
        do_tick(); read_all("R10 counters after halt");

        // R12 read halt set together with a tick
        bus_write(0, 8'h40, 1'b1); read_all("R12 update not cut short");
        do_tick(); read_chk(1, "R12 frozen afterwards");
        bus_write(0, 8'h00, 1'b0);

        // random mix
        for (int it = 0; it < 600; it++) begin
            int r = $urandom % 12;
            int f;
            if (r < 5) do_tick();
            else if (r < 7) read_chk($urandom % 8, "R3 R4 random read");
            else if (r == 7) bus_write(0, {1'b0, 1'($urandom), 6'd0}, 1'($urandom));
            else if (r == 8) begin
                f = 2 + ($urandom % 2);
                bus_write(f, enc($urandom % (f == 3 ? 24 : 60)), 1'($urandom));
            end else if (r == 9)
                bus_write(1, {($urandom % 5 == 0) ? 1'b1 : 1'b0, enc($urandom % 60)[6:0]}, 1'b0);
            else if (r == 10)
                set_time($urandom % 100, 1 + $urandom % 12, 28, 1 + $urandom % 7,
                         23, 59, 55 + $urandom % 5);
            else read_all("R7 R8 R9 random sweep");
        end
        bus_write(1, enc(0), 1'b0);
        bus_write(0, 8'h00, 1'b0);
        do_tick();
        read_all("R3 final");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule